// File: doc/BRIEF.md
# Timer Channel Input Capture with Coherent Byte Reads

This block is a single timer channel used as an input-capture unit. An external pin is brought into the clock domain through a chain of flip-flops. When the chosen transition appears on the synchronised signal, the channel copies the free-running counter value into a 16-bit capture register. It also sets its event flag and, when enabled, raises an interrupt. The counter comes from outside the block. When a debug halt stops that counter, the channel keeps capturing and stores the stopped value.

Software reads the capture register one byte at a time, through a high-byte strobe and a low-byte strobe that share one read-data bus. A small read-coherency machine makes sure both bytes come from the same 16-bit value, whichever byte is read first. The first byte read copies the other byte into a buffer. The second read returns that buffer.

The machine has three states:
- RD_OPEN: nothing is buffered.
- RD_HOLD_LO: the high byte was read, so the low byte is buffered.
- RD_HOLD_HI: the low byte was read, so the high byte is buffered.

Its transitions are:
- RD_OPEN goes to RD_HOLD_LO on a high read, and to RD_HOLD_HI on a low read.
- RD_HOLD_LO returns to RD_OPEN on a low read. A repeated high read keeps it in RD_HOLD_LO.
- RD_HOLD_HI returns to RD_OPEN on a high read. A repeated low read keeps it in RD_HOLD_HI.
- A write to the channel control register sends every state to RD_OPEN. This takes priority over any read.

Top module: `icap_channel`

## Requirements
- R1: Capture happens only when all of the following hold: `pair_dual_en`, `pair_combine` and `cnt_centre` are 0, the control mode field (ctl bits 3:2) is 00, and the edge field (ctl bits 1:0) is not 00. In any other setting, pin activity changes neither the capture register nor the flag.
- R2: The edge field selects which pin transitions cause a capture: 01 means rising only, 10 means falling only, 11 means both. Suppose the pin changes before rising clock edge k. The capture register then holds the `cnt_val` value present at edge k+2, and `ch_flag` reads 1 after that same edge and not before it.
- R3: `ch_flag` is set in the same cycle as the capture. A control write with bit 5 equal to 0 clears it. A control write with bit 5 equal to 1 leaves it unchanged.
- R4: `ch_irq` is 1 exactly when `ch_flag` is 1 and the interrupt-enable bit (ctl bit 4) is 1.
- R5: The pin passes through a two-stage synchroniser. A pulse that stays at each level for at least two clock cycles is detected, which keeps the input within one quarter of the clock rate.
- R6: `rd_data` returns the addressed byte combinationally while `rd_hi` or `rd_lo` is 1. Reading high then low, or low then high, returns the two bytes of one captured value. If both strobes are 1, the high read takes priority.
- R7: A control write forces the coherency machine back to RD_OPEN. The next byte read then returns the live value, not the stale buffer.
- R8: In capture mode, `val_wr_hi` and `val_wr_lo` have no effect on the capture register. Outside capture mode, they load the byte on `val_wdata` into the high or low half.
- R9: If a capture occurs while a byte is buffered, the live register takes the new value and the buffered byte keeps the old one. Once the second byte has been read, the machine is open and a new pair of reads returns the new value.
- R10: Capture does not depend on the counter advancing. With `cnt_val` held still, each selected edge stores the held value again and sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Current timer counter value |
| pair_dual_en | input | 1 | Dual-edge capture enable of the channel pair; blocks single capture |
| pair_combine | input | 1 | Combine enable of the channel pair; blocks single capture |
| cnt_centre | input | 1 | Centre-aligned counting active; blocks single capture |
| ch_pin | input | 1 | Asynchronous channel input pin |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data: [5] flag keep, [4] interrupt enable, [3:2] mode, [1:0] edge select |
| val_wr_hi | input | 1 | Write strobe, high byte of the value register |
| val_wr_lo | input | 1 | Write strobe, low byte of the value register |
| val_wdata | input | 8 | Value write data byte |
| rd_hi | input | 1 | Read strobe, high byte |
| rd_lo | input | 1 | Read strobe, low byte |
| rd_data | output | 8 | Read data byte |
| ch_flag | output | 1 | Channel event flag |
| ch_irq | output | 1 | Channel interrupt request |

## Verification
The bench targets the exact capture latency. A design with one synchroniser stage too few would raise the flag a cycle early, and one with an extra stage would store a later counter value. It checks each edge-select code against the transition it must ignore, so a swapped encoding would capture on the wrong polarity. It also checks that each disabling bit (dual-edge, combine, centre-aligned, mode field) blocks capture on its own. The coherency tests read in both byte orders and insert a capture between the two reads. A design that skipped the buffer would return a torn value, and one that never released the latch would keep returning a stale byte. A further test writes the control register in the middle of a read pair, and would catch a latch that survives that write.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int CTL_W = 6;

    typedef enum logic [1:0] {
        RD_OPEN    = 2'd0,
        RD_HOLD_LO = 2'd1,
        RD_HOLD_HI = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic       int_en;
        logic [1:0] mode;
        logic [1:0] edge_sel;
    } ch_ctl_t;
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       enable,
    input  logic [1:0] edge_sel,
    output logic       evt
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;
    logic                   cur;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign cur = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    always_comb begin
        evt = enable && ((edge_sel[0] && cur && !prev_q) ||
                         (edge_sel[1] && !cur && prev_q));
    end
endmodule

// File: rtl/icap_coherent_rd.sv
module icap_coherent_rd
    import icap_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  live,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic              clr,
    output logic [BYTE_W-1:0] rd_data,
    output rd_state_e         state
);
    rd_state_e         nxt;
    logic [BYTE_W-1:0] buf_q;
    logic [BYTE_W-1:0] live_hi;
    logic [BYTE_W-1:0] live_lo;

    assign live_hi = live[CNT_W-1:BYTE_W];
    assign live_lo = live[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_OPEN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_OPEN: begin
                if (rd_hi)      nxt = RD_HOLD_LO;
                else if (rd_lo) nxt = RD_HOLD_HI;
            end
            RD_HOLD_LO: begin
                if (rd_lo && !rd_hi) nxt = RD_OPEN;
            end
            RD_HOLD_HI: begin
                if (rd_hi) nxt = RD_OPEN;
            end
            default: nxt = RD_OPEN;
        endcase
        if (clr) nxt = RD_OPEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (!clr && state == RD_OPEN) begin
            if (rd_hi)      buf_q <= live_lo;
            else if (rd_lo) buf_q <= live_hi;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hi)      rd_data = (state == RD_HOLD_HI) ? buf_q : live_hi;
        else if (rd_lo) rd_data = (state == RD_HOLD_LO) ? buf_q : live_lo;
    end
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pair_dual_en,
    input  logic              pair_combine,
    input  logic              cnt_centre,
    input  logic              ch_pin,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              val_wr_hi,
    input  logic              val_wr_lo,
    input  logic [BYTE_W-1:0] val_wdata,
    input  logic              rd_hi,
    input  logic              rd_lo,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ch_flag,
    output logic              ch_irq
);
    ch_ctl_t          ctl_q;
    logic             cap_mode;
    logic             cap_evt;
    logic [CNT_W-1:0] cap_val;
    rd_state_e        rd_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ch_ctl_t'(ctl_wdata[CTL_W-2:0]);
    end

    always_comb begin
        cap_mode = !pair_dual_en && !pair_combine && !cnt_centre &&
                   (ctl_q.mode == 2'b00) && (ctl_q.edge_sel != 2'b00);
    end

    icap_sync_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ch_pin),
        .enable   (cap_mode),
        .edge_sel (ctl_q.edge_sel),
        .evt      (cap_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (cap_evt) begin
            cap_val <= cnt_val;
        end else if (!cap_mode) begin
            if (val_wr_hi) cap_val[CNT_W-1:BYTE_W] <= val_wdata;
            if (val_wr_lo) cap_val[BYTE_W-1:0]     <= val_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ch_flag <= 1'b0;
        else if (cap_evt)                     ch_flag <= 1'b1;
        else if (ctl_wr && !ctl_wdata[CTL_W-1]) ch_flag <= 1'b0;
    end

    assign ch_irq = ch_flag && ctl_q.int_en;

    icap_coherent_rd #(
        .BYTE_W (BYTE_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (cap_val),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo),
        .clr     (ctl_wr),
        .rd_data (rd_data),
        .state   (rd_state)
    );
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_evt,
    input logic             cap_mode,
    input logic             flag,
    input logic             irq,
    input logic             wr_hi,
    input logic             wr_lo,
    input logic             ctl_wr,
    input rd_state_e        rd_state
);
    AST_NO_EVT_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_mode |-> !cap_evt); // R1

    AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == $past(cnt_val)); // R2

    AST_FLAG_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag); // R3

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R4

    AST_CTL_OPENS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> rd_state == RD_OPEN); // R7

    AST_VAL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && (wr_hi || wr_lo) && !cap_evt) |=> $stable(cap_val)); // R8
endmodule

bind icap_channel icap_channel_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_val  (cnt_val),
    .cap_val  (cap_val),
    .cap_evt  (cap_evt),
    .cap_mode (cap_mode),
    .flag     (ch_flag),
    .irq      (ch_irq),
    .wr_hi    (val_wr_hi),
    .wr_lo    (val_wr_lo),
    .ctl_wr   (ctl_wr),
    .rd_state (rd_state)
);

// File: tb/icap_channel_test.sv
`timescale 1ns/1ps
module icap_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        pair_dual_en = 1'b0;
    logic        pair_combine = 1'b0;
    logic        cnt_centre = 1'b0;
    logic        ch_pin = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic        val_wr_hi = 1'b0;
    logic        val_wr_lo = 1'b0;
    logic [7:0]  val_wdata = '0;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic [7:0]  rd_data;
    logic        ch_flag;
    logic        ch_irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    icap_channel uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val),
        .pair_dual_en(pair_dual_en), .pair_combine(pair_combine),
        .cnt_centre(cnt_centre), .ch_pin(ch_pin),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .val_wr_hi(val_wr_hi), .val_wr_lo(val_wr_lo), .val_wdata(val_wdata),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data),
        .ch_flag(ch_flag), .ch_irq(ch_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic keep, input logic ie, input logic [1:0] mode,
                          input logic [1:0] edge_sel);
        @(negedge clk);
        ctl_wdata = {keep, ie, mode, edge_sel};
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        ch_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_hi(output logic [7:0] v);
        @(negedge clk);
        rd_hi = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_hi = 1'b0;
    endtask

    task automatic read_lo(output logic [7:0] v);
        @(negedge clk);
        rd_lo = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_lo = 1'b0;
    endtask

    task automatic read_word_hf(output logic [15:0] w);
        logic [7:0] h, l;
        read_hi(h);
        read_lo(l);
        w = {h, l};
    endtask

    task automatic read_word_lf(output logic [15:0] w);
        logic [7:0] h, l;
        read_lo(l);
        read_hi(h);
        w = {h, l};
    endtask

    task automatic t_reset;
        logic [15:0] w;
        chk("R3 reset flag", 16'(ch_flag), 16'h0);
        chk("R4 reset irq", 16'(ch_irq), 16'h0);
        read_word_hf(w);
        chk("R6 reset value", w, 16'h0000);
    endtask

    task automatic t_rise;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'h1234;
        @(negedge clk);
        ch_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 flag not before third edge", 16'(ch_flag), 16'h0);
        @(negedge clk);
        chk("R2 flag at third edge", 16'(ch_flag), 16'h1);
        cnt_val = 16'h9999;
        repeat (2) @(negedge clk);
        read_word_hf(w);
        chk("R2 rising capture value", w, 16'h1234);
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'h5555;
        set_pin(1'b0);
        chk("R2 falling ignored under 01", 16'(ch_flag), 16'h0);
        read_word_lf(w);
        chk("R2 value kept under 01 fall", w, 16'h1234);
    endtask

    task automatic t_fall;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b10);
        cnt_val = 16'h0F0F;
        set_pin(1'b1);
        chk("R2 rising ignored under 10", 16'(ch_flag), 16'h0);
        cnt_val = 16'hBEEF;
        set_pin(1'b0);
        chk("R2 falling flag under 10", 16'(ch_flag), 16'h1);
        read_word_hf(w);
        chk("R2 falling capture value", w, 16'hBEEF);
    endtask

    task automatic t_both;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b11);
        cnt_val = 16'h1111;
        set_pin(1'b1);
        read_word_hf(w);
        chk("R2 both: rise value", w, 16'h1111);
        cnt_val = 16'h2222;
        set_pin(1'b0);
        read_word_lf(w);
        chk("R2 both: fall value", w, 16'h2222);
    endtask

    task automatic t_short_pulse;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'h3333;
        @(negedge clk);
        ch_pin = 1'b1;
        repeat (2) @(negedge clk);
        ch_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 two-cycle pulse flagged", 16'(ch_flag), 16'h1);
        read_word_hf(w);
        chk("R5 two-cycle pulse value", w, 16'h3333);
    endtask

    task automatic t_mode_gate;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b00);
        cnt_val = 16'h4444;
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R1 edge 00 no flag", 16'(ch_flag), 16'h0);
        wr_ctl(1'b0, 1'b0, 2'b01, 2'b11);
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R1 mode 01 no flag", 16'(ch_flag), 16'h0);
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b11);
        pair_dual_en = 1'b1;
        set_pin(1'b1);
        pair_dual_en = 1'b0;
        pair_combine = 1'b1;
        set_pin(1'b0);
        pair_combine = 1'b0;
        cnt_centre = 1'b1;
        set_pin(1'b1);
        cnt_centre = 1'b0;
        chk("R1 pair/centre bits block", 16'(ch_flag), 16'h0);
        read_word_hf(w);
        chk("R1 value unchanged", w, 16'h3333);
        set_pin(1'b0);
        chk("R1 capture resumes", 16'(ch_flag), 16'h1);
    endtask

    task automatic t_irq;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'h6666;
        set_pin(1'b1);
        chk("R4 flag without enable", 16'(ch_flag), 16'h1);
        chk("R4 irq masked", 16'(ch_irq), 16'h0);
        wr_ctl(1'b1, 1'b1, 2'b00, 2'b01);
        chk("R3 keep bit preserves flag", 16'(ch_flag), 16'h1);
        chk("R4 irq enabled", 16'(ch_irq), 16'h1);
        wr_ctl(1'b0, 1'b1, 2'b00, 2'b01);
        chk("R3 flag cleared", 16'(ch_flag), 16'h0);
        chk("R4 irq drops with flag", 16'(ch_irq), 16'h0);
        set_pin(1'b0);
    endtask

    task automatic t_coherent;
        logic [15:0] w;
        logic [7:0] b;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'hA1B2;
        set_pin(1'b1);
        read_word_hf(w);
        chk("R6 high-first", w, 16'hA1B2);
        read_word_lf(w);
        chk("R6 low-first", w, 16'hA1B2);
        @(negedge clk);
        rd_hi = 1'b1;
        rd_lo = 1'b1;
        #1 b = rd_data;
        @(negedge clk);
        rd_hi = 1'b0;
        rd_lo = 1'b0;
        chk("R6 high priority", 16'(b), 16'h00A1);
        read_lo(b);
        chk("R6 low after dual strobe", 16'(b), 16'h00B2);
        set_pin(1'b0);
    endtask

    task automatic t_hold_capture;
        logic [7:0] b;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b11);
        cnt_val = 16'hA1B2;
        set_pin(1'b1);
        read_hi(b);
        chk("R9 first high", 16'(b), 16'h00A1);
        cnt_val = 16'hC3D4;
        set_pin(1'b0);
        read_lo(b);
        chk("R9 buffered low kept", 16'(b), 16'h00B2);
        read_word_lf(w);
        chk("R9 released, new value", w, 16'hC3D4);
    endtask

    task automatic t_ctl_reset;
        logic [7:0] b;
        read_hi(b);
        chk("R7 first high", 16'(b), 16'h00C3);
        cnt_val = 16'hE5F6;
        set_pin(1'b1);
        wr_ctl(1'b1, 1'b0, 2'b00, 2'b11);
        read_lo(b);
        chk("R7 live low after ctl write", 16'(b), 16'h00F6);
        read_hi(b);
        chk("R7 high pairs with live low", 16'(b), 16'h00E5);
        set_pin(1'b0);
    endtask

    task automatic t_write;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b01);
        cnt_val = 16'h7A7B;
        set_pin(1'b1);
        @(negedge clk);
        val_wdata = 8'h99; val_wr_hi = 1'b1;
        @(negedge clk);
        val_wr_hi = 1'b0; val_wdata = 8'h88; val_wr_lo = 1'b1;
        @(negedge clk);
        val_wr_lo = 1'b0;
        read_word_hf(w);
        chk("R8 writes ignored in capture", w, 16'h7A7B);
        wr_ctl(1'b0, 1'b0, 2'b01, 2'b01);
        @(negedge clk);
        val_wdata = 8'h99; val_wr_hi = 1'b1;
        @(negedge clk);
        val_wr_hi = 1'b0; val_wdata = 8'h88; val_wr_lo = 1'b1;
        @(negedge clk);
        val_wr_lo = 1'b0;
        read_word_lf(w);
        chk("R8 writes load outside capture", w, 16'h9988);
        set_pin(1'b0);
    endtask

    task automatic t_freeze;
        logic [15:0] w;
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b11);
        cnt_val = 16'h7777;
        set_pin(1'b1);
        chk("R10 frozen count flag 1", 16'(ch_flag), 16'h1);
        wr_ctl(1'b0, 1'b0, 2'b00, 2'b11);
        chk("R10 flag cleared", 16'(ch_flag), 16'h0);
        set_pin(1'b0);
        chk("R10 frozen count flag again", 16'(ch_flag), 16'h1);
        read_word_hf(w);
        chk("R10 frozen value", w, 16'h7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_short_pulse();
        t_mode_gate();
        t_irq();
        t_coherent();
        t_hold_capture();
        t_ctl_reset();
        t_write();
        t_freeze();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule